// File: doc/BRIEF.md
# Power-up reset delay sequencer

This block keeps a processor core in reset after a power event until both the supply and the clock can be trusted. It runs on two clocks. A slow free-running tick clock (`tick_clk`) is always running and drives the sequencing state machine and the millisecond timers. The oscillator clock (`osc_clk`) may still be settling. It drives the oscillator start-up counter and the core reset output. The tick clock must be slower than the oscillator clock.

The reset cause decides which stages run. Stages are always taken in this order: power-on delay, power-up timer, oscillator start-up count, PLL lock wait, running.
- A power-on event starts the power-on delay, which hands over to the power-up timer.
- A brown-out event starts the power-up timer directly.
- If the power-up timer is disabled by its configuration input, the sequence goes straight to the start-up count.
- After the start-up count, the PLL lock wait follows only in PLL mode and only for a power-caused sequence.
- An external reset pin asserted while running re-runs the start-up count alone.

The states are named ST_PORD (power-on delay), ST_PWRT (power-up timer), ST_OST (start-up count), ST_PLL (PLL lock wait) and ST_RUN (running). The transitions are:
- `pord_done`: ST_PORD to ST_PWRT, or to ST_OST when the timer is disabled.
- `pwrt_done`: ST_PWRT to ST_OST.
- `ost_done`: ST_OST to ST_PLL, or to ST_RUN.
- `pll_done`: ST_PLL to ST_RUN.
- `pin_hit`: ST_PLL or ST_RUN to ST_OST.
- `bor_hit`: any state to ST_PWRT, or to ST_OST.
- `por_hit`: asynchronous, any state to ST_PORD.

Top module: `pwrup_seq`

## Requirements
- R1: `stage` is one-hot with bit 0 = ST_PORD, bit 1 = ST_PWRT, bit 2 = ST_OST, bit 3 = ST_PLL, bit 4 = ST_RUN. While `por_in` is high, `stage` reads 5'b00001 and `core_rst` reads 1.
- R2: After `por_in` falls, ST_PORD lasts exactly POR_TICKS tick cycles. It then goes to ST_PWRT when `pwrt_enable` = 1, or to ST_OST when it is 0.
- R3: ST_PWRT lasts exactly PWRT_MS*1000/TICK_US tick cycles. It is entered only from ST_PORD or by a brown-out, and only when `pwrt_enable` = 1.
- R4: ST_OST ends only after OST_CYCLES consecutive `osc_clk` rising edges have been counted while the count is requested. Two-flop synchronizers in each direction add a few tick cycles of latency.
- R5: ST_PLL follows ST_OST only when `pll_sel` = 1 and the sequence was started by a power-on or brown-out event. It lasts exactly PLL_MS*1000/TICK_US tick cycles.
- R6: A one-cycle `bor_in` pulse in any state restarts the sequence on the next tick edge, at ST_PWRT (or ST_OST when `pwrt_enable` = 0). The stage's timer or count restarts from zero.
- R7: `ext_rst_n` low has two effects.
  - During ST_OST, ST_PLL or ST_RUN, it forces ST_OST and holds the start-up count cleared until the pin rises.
  - When it comes from ST_RUN, the following sequence is ST_OST then ST_RUN.
  - During ST_PORD or ST_PWRT it leaves the stage and its timer unchanged.
- R8: `core_rst` stays 1 whenever `stage` is not ST_RUN. It goes to 0 synchronously to `osc_clk`, within 4 `osc_clk` cycles after `stage` reaches ST_RUN.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| tick_clk | input | 1 | Slow free-running tick clock for the sequencer and millisecond timers |
| osc_clk | input | 1 | Oscillator clock being qualified |
| por_in | input | 1 | Power-on reset, active high, asynchronous |
| bor_in | input | 1 | Brown-out reset pulse, active high, synchronous to tick_clk |
| ext_rst_n | input | 1 | External reset pin, active low, asynchronous |
| pwrt_enable | input | 1 | Configuration: 1 enables the power-up timer |
| pll_sel | input | 1 | Configuration: 1 selects PLL clock mode |
| core_rst | output | 1 | Core reset, active high, released synchronously to osc_clk |
| stage | output | 5 | One-hot current stage |

## Verification
A wrong stage choice shows on `stage` at the very next tick edge after the event: a skipped power-up timer, or a PLL wait after a pin reset, appears as a wrong bit pattern in the visited-stage set. A wrong timer limit shows as a stage length that is off by whole tick cycles. The bench measures each stage's length exactly, except the start-up count, whose synchronizer latency it bounds by a window. A stale start-up done flag, or a missing release of the reset, shows within one sequence: either ST_OST ends too early, or `core_rst` is still high a few oscillator cycles after ST_RUN is reached.

// File: rtl/pwrup_seq_pkg.sv
package pwrup_seq_pkg;

    // One-hot stage codes; bit positions are visible on the stage port
    typedef enum logic [4:0] {
        ST_PORD = 5'b00001,
        ST_PWRT = 5'b00010,
        ST_OST  = 5'b00100,
        ST_PLL  = 5'b01000,
        ST_RUN  = 5'b10000
    } stage_e;

endpackage

// File: rtl/pwrup_sync2.sv
module pwrup_sync2 #(
    parameter int        W  = 1,
    parameter logic      RV = 1'b0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] meta_q;
    logic [W-1:0] hold_q;

    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            meta_q <= {W{RV}};
            hold_q <= {W{RV}};
        end else begin
            meta_q <= d;
            hold_q <= meta_q;
        end
    end

    assign q = hold_q;

endmodule

// File: rtl/pwrup_ost_counter.sv
module pwrup_ost_counter #(
    parameter int OST_CYCLES = 1024
) (
    input  logic osc_clk,
    input  logic rst,
    input  logic go_async,
    output logic done
);

    localparam int CW = (OST_CYCLES > 1) ? $clog2(OST_CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(OST_CYCLES - 1);

    logic          go_s;
    logic [CW-1:0] cnt_q;
    logic          done_q;

    pwrup_sync2 #(.W(1), .RV(1'b0)) u_go_sync (
        .clk (osc_clk),
        .rst (rst),
        .d   (go_async),
        .q   (go_s)
    );

    // Counts oscillator edges while requested; a dropped request clears it
    always_ff @(posedge osc_clk or posedge rst) begin
        if (rst) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!go_s) begin
            cnt_q  <= '0;
            done_q <= 1'b0;
        end else if (!done_q) begin
            if (cnt_q == LAST) begin
                done_q <= 1'b1;
            end else begin
                cnt_q <= cnt_q + 1'b1;
            end
        end
    end

    assign done = done_q;

    // R4: completion is only reported for a request that was present
    assert_done_needs_go_R4: assert property (@(posedge osc_clk) disable iff (rst)
        done_q |-> $past(go_s));

    // R4: completion rises only at the final count
    assert_done_at_last_R4: assert property (@(posedge osc_clk) disable iff (rst)
        $rose(done_q) |-> ($past(cnt_q) == LAST));

endmodule

// File: rtl/pwrup_fsm.sv
module pwrup_fsm
    import pwrup_seq_pkg::*;
#(
    parameter int POR_TICKS  = 16,
    parameter int PWRT_TICKS = 72000,
    parameter int PLL_TICKS  = 2000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       bor,
    input  logic       pin_ok,
    input  logic       pwrt_en,
    input  logic       pll_sel,
    input  logic       ost_done,
    output logic       ost_go,
    output logic       run,
    output logic [4:0] stage
);

    localparam int MAX_AB = (POR_TICKS > PWRT_TICKS) ? POR_TICKS : PWRT_TICKS;
    localparam int MAXT   = (MAX_AB > PLL_TICKS) ? MAX_AB : PLL_TICKS;
    localparam int CW     = $clog2(MAXT + 1);
    localparam logic [CW-1:0] POR_LAST  = CW'(POR_TICKS - 1);
    localparam logic [CW-1:0] PWRT_LAST = CW'(PWRT_TICKS - 1);
    localparam logic [CW-1:0] PLL_LAST  = CW'(PLL_TICKS - 1);

    stage_e        state, nxt;
    logic [CW-1:0] cnt_q;
    logic          cnt_clr;
    logic          pwr_cause_q, cause_nxt;
    logic          armed_q, armed_nxt;
    logic          go_q, run_q;

    // Next-state selection and transition naming
    always_comb begin
        nxt       = state;
        cnt_clr   = 1'b0;
        cause_nxt = pwr_cause_q;
        if (bor) begin                                   // bor_hit
            nxt       = pwrt_en ? ST_PWRT : ST_OST;
            cnt_clr   = 1'b1;
            cause_nxt = 1'b1;
        end else begin
            unique case (state)
                ST_PORD: if (cnt_q == POR_LAST) begin    // pord_done
                    nxt     = pwrt_en ? ST_PWRT : ST_OST;
                    cnt_clr = 1'b1;
                end
                ST_PWRT: if (cnt_q == PWRT_LAST) begin   // pwrt_done
                    nxt     = ST_OST;
                    cnt_clr = 1'b1;
                end
                ST_OST: if (pin_ok && armed_q && ost_done) begin  // ost_done
                    nxt     = (pll_sel && pwr_cause_q) ? ST_PLL : ST_RUN;
                    cnt_clr = 1'b1;
                end
                ST_PLL: begin
                    if (!pin_ok) begin                   // pin_hit
                        nxt     = ST_OST;
                        cnt_clr = 1'b1;
                    end else if (cnt_q == PLL_LAST) begin // pll_done
                        nxt     = ST_RUN;
                        cnt_clr = 1'b1;
                    end
                end
                ST_RUN: if (!pin_ok) begin               // pin_hit
                    nxt       = ST_OST;
                    cnt_clr   = 1'b1;
                    cause_nxt = 1'b0;
                end
                default: begin
                    nxt     = ST_PORD;
                    cnt_clr = 1'b1;
                end
            endcase
        end
        // Armed once a low done has been seen in an undisturbed start-up stage
        if (bor || !pin_ok || state != ST_OST || nxt != ST_OST)
            armed_nxt = 1'b0;
        else
            armed_nxt = armed_q | ~ost_done;
    end

    // State register and stage timer
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            state       <= ST_PORD;
            cnt_q       <= '0;
            pwr_cause_q <= 1'b1;
            armed_q     <= 1'b0;
        end else begin
            state       <= nxt;
            pwr_cause_q <= cause_nxt;
            armed_q     <= armed_nxt;
            if (cnt_clr)
                cnt_q <= '0;
            else if (state == ST_PORD || state == ST_PWRT || state == ST_PLL)
                cnt_q <= cnt_q + 1'b1;
        end
    end

    // Registered outputs toward the oscillator domain
    always_ff @(posedge clk or posedge rst) begin
        if (rst) begin
            go_q  <= 1'b0;
            run_q <= 1'b0;
        end else begin
            go_q  <= (state == ST_OST) && pin_ok && armed_q;
            run_q <= (nxt == ST_RUN);
        end
    end

    assign ost_go = go_q;
    assign run    = run_q;
    assign stage  = state;

    assert_onehot_R1: assert property (@(posedge clk) disable iff (rst)
        $countones(state) == 1);

    assert_pwrt_entry_R3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PWRT && $past(state) != ST_PWRT)
            |-> ($past(pwrt_en) && ($past(state) == ST_PORD || $past(bor))));

    assert_pll_entry_R5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_PLL && $past(state) != ST_PLL)
            |-> ($past(pll_sel) && $past(pwr_cause_q) && $past(state) == ST_OST));

    assert_bor_restart_R6: assert property (@(posedge clk) disable iff (rst)
        bor |=> (state == ($past(pwrt_en) ? ST_PWRT : ST_OST)) && (cnt_q == '0));

    assert_pin_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (state == ST_OST && !pin_ok && !bor) |=> (state == ST_OST && !go_q));

endmodule

// File: rtl/pwrup_seq.sv
module pwrup_seq
    import pwrup_seq_pkg::*;
#(
    parameter int POR_TICKS  = 16,
    parameter int TICK_US    = 1,
    parameter int PWRT_MS    = 72,
    parameter int PLL_MS     = 2,
    parameter int OST_CYCLES = 1024
) (
    input  logic       tick_clk,
    input  logic       osc_clk,
    input  logic       por_in,
    input  logic       bor_in,
    input  logic       ext_rst_n,
    input  logic       pwrt_enable,
    input  logic       pll_sel,
    output logic       core_rst,
    output logic [4:0] stage
);

    localparam int PWRT_TICKS = PWRT_MS * 1000 / TICK_US;
    localparam int PLL_TICKS  = PLL_MS * 1000 / TICK_US;

    logic pin_ok;
    logic ost_go;
    logic ost_done_osc;
    logic ost_done_tick;
    logic run_tick;
    logic run_osc;
    logic core_rst_q;

    pwrup_sync2 #(.W(1), .RV(1'b0)) u_pin_sync (
        .clk (tick_clk),
        .rst (por_in),
        .d   (ext_rst_n),
        .q   (pin_ok)
    );

    pwrup_fsm #(
        .POR_TICKS  (POR_TICKS),
        .PWRT_TICKS (PWRT_TICKS),
        .PLL_TICKS  (PLL_TICKS)
    ) u_fsm (
        .clk      (tick_clk),
        .rst      (por_in),
        .bor      (bor_in),
        .pin_ok   (pin_ok),
        .pwrt_en  (pwrt_enable),
        .pll_sel  (pll_sel),
        .ost_done (ost_done_tick),
        .ost_go   (ost_go),
        .run      (run_tick),
        .stage    (stage)
    );

    pwrup_ost_counter #(.OST_CYCLES(OST_CYCLES)) u_ost (
        .osc_clk  (osc_clk),
        .rst      (por_in),
        .go_async (ost_go),
        .done     (ost_done_osc)
    );

    pwrup_sync2 #(.W(1), .RV(1'b0)) u_done_sync (
        .clk (tick_clk),
        .rst (por_in),
        .d   (ost_done_osc),
        .q   (ost_done_tick)
    );

    pwrup_sync2 #(.W(1), .RV(1'b0)) u_run_sync (
        .clk (osc_clk),
        .rst (por_in),
        .d   (run_tick),
        .q   (run_osc)
    );

    always_ff @(posedge osc_clk or posedge por_in) begin
        if (por_in)
            core_rst_q <= 1'b1;
        else
            core_rst_q <= ~run_osc;
    end

    assign core_rst = core_rst_q;

    // R8: two tick cycles outside the running stage leave the core in reset
    assert_rst_outside_run_R8: assert property (@(posedge tick_clk) disable iff (por_in)
        (stage != ST_RUN && $past(stage) != ST_RUN && $past(stage, 2) != ST_RUN)
            |-> core_rst);

endmodule

// File: tb/pwrup_seq_bench.sv
module pwrup_seq_bench;

    localparam int P_POR    = 6;
    localparam int P_TICKUS = 500;
    localparam int P_OST    = 64;
    localparam int T_PWRT   = 72 * 1000 / P_TICKUS;   // 144 ticks
    localparam int T_PLL    = 2 * 1000 / P_TICKUS;    // 4 ticks
    localparam int OST_LO   = P_OST * 20 / 110;       // osc 20 ns, tick 110 ns
    localparam int OST_HI   = OST_LO + 12;

    logic       tick_clk = 1'b0;
    logic       osc_clk  = 1'b0;
    logic       por_in   = 1'b1;
    logic       bor_in   = 1'b0;
    logic       ext_rst_n = 1'b1;
    logic       pwrt_enable = 1'b1;
    logic       pll_sel  = 1'b0;
    logic       core_rst;
    logic [4:0] stage;

    always #10 osc_clk  = ~osc_clk;
    always #55 tick_clk = ~tick_clk;

    pwrup_seq #(
        .POR_TICKS  (P_POR),
        .TICK_US    (P_TICKUS),
        .PWRT_MS    (72),
        .PLL_MS     (2),
        .OST_CYCLES (P_OST)
    ) u_pwrup_seq (
        .tick_clk    (tick_clk),
        .osc_clk     (osc_clk),
        .por_in      (por_in),
        .bor_in      (bor_in),
        .ext_rst_n   (ext_rst_n),
        .pwrt_enable (pwrt_enable),
        .pll_sel     (pll_sel),
        .core_rst    (core_rst),
        .stage       (stage)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;

    logic [4:0] seen;
    int         dur [5];
    logic       last_rst;

    // cause: 0 power-on, 1 brown-out, 2 pin; then pwrt_enable, pll_sel, expected stage set
    localparam logic [8:0] VEC [8] = '{
        {2'd0, 1'b1, 1'b0, 5'b00111},
        {2'd0, 1'b1, 1'b1, 5'b01111},
        {2'd0, 1'b0, 1'b1, 5'b01101},
        {2'd0, 1'b0, 1'b0, 5'b00101},
        {2'd1, 1'b1, 1'b1, 5'b01110},
        {2'd1, 1'b0, 1'b0, 5'b00100},
        {2'd2, 1'b1, 1'b1, 5'b00100},
        {2'd1, 1'b1, 1'b0, 5'b00110}
    };

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    // Walks the stages until running, recording the set visited and their lengths
    task automatic measure();
        int guard = 0;
        seen = '0;
        for (int i = 0; i < 5; i++) dur[i] = 0;
        last_rst = 1'b1;
        while (stage != 5'b10000 && guard < 4000) begin
            seen = seen | stage;
            for (int i = 0; i < 5; i++) if (stage[i]) dur[i]++;
            last_rst = core_rst;
            @(negedge tick_clk);
            guard++;
        end
        chk(guard < 4000, "R8 reached running", guard, 0);
    endtask

    task automatic check_release();
        chk(last_rst == 1'b1, "R8 held before running", int'(last_rst), 1);
        repeat (4) @(negedge osc_clk);
        chk(core_rst == 1'b0, "R8 released in running", int'(core_rst), 0);
    endtask

    task automatic check_stages(input logic [4:0] exp_mask);
        chk(seen == exp_mask, "R2/R3/R5/R7 stage set", int'(seen), int'(exp_mask));
        if (exp_mask[0]) chk(dur[0] == P_POR, "R2 power-on delay length", dur[0], P_POR);
        if (exp_mask[1]) chk(dur[1] == T_PWRT, "R3 power-up timer length", dur[1], T_PWRT);
        if (exp_mask[3]) chk(dur[3] == T_PLL, "R5 PLL wait length", dur[3], T_PLL);
        chk(dur[2] >= OST_LO && dur[2] <= OST_HI, "R4 start-up count length", dur[2], OST_LO);
    endtask

    task automatic do_por();
        @(negedge tick_clk);
        por_in = 1'b1;
        repeat (2) @(negedge tick_clk);
        chk(stage == 5'b00001, "R1 stage in reset", int'(stage), 1);
        chk(core_rst == 1'b1, "R1 core reset in reset", int'(core_rst), 1);
        por_in = 1'b0;
    endtask

    task automatic do_bor();
        @(negedge tick_clk);
        bor_in = 1'b1;
        @(negedge tick_clk);
        bor_in = 1'b0;
    endtask

    task automatic do_pin();
        @(negedge tick_clk);
        ext_rst_n = 1'b0;
        repeat (4) @(negedge tick_clk);
        chk(stage == 5'b00100, "R7 pin forces start-up stage", int'(stage), 4);
        chk(core_rst == 1'b1, "R8 pin reasserts core reset", int'(core_rst), 1);
        ext_rst_n = 1'b1;
    endtask

    initial begin
        #2000000;
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        finish_run();
    end

    initial begin
        // Table walk: each entry starts from running, except the first
        for (int v = 0; v < 8; v++) begin
            pwrt_enable = VEC[v][6];
            pll_sel     = VEC[v][5];
            case (VEC[v][8:7])
                2'd0:    do_por();
                2'd1:    do_bor();
                default: do_pin();
            endcase
            measure();
            check_stages(VEC[v][4:0]);
            check_release();
        end

        // R6: brown-out halfway through the power-up timer restarts it
        pwrt_enable = 1'b1;
        pll_sel     = 1'b0;
        do_por();
        while (stage != 5'b00010) @(negedge tick_clk);
        repeat (40) @(negedge tick_clk);
        do_bor();
        measure();
        chk(dur[1] == T_PWRT, "R6 timer restarted by brown-out", dur[1], T_PWRT);
        chk(seen == 5'b00110, "R6 restart stage set", int'(seen), 6);
        check_release();

        // R6: brown-out inside the start-up stage restarts the count
        pwrt_enable = 1'b0;
        do_bor();
        repeat (6) @(negedge tick_clk);
        do_bor();
        measure();
        chk(dur[2] >= OST_LO, "R6 start-up count restarted", dur[2], OST_LO);
        check_release();

        // R7: pin low during the power-up timer is ignored there, then holds start-up
        pwrt_enable = 1'b1;
        do_por();
        while (stage != 5'b00010) @(negedge tick_clk);
        repeat (10) @(negedge tick_clk);
        ext_rst_n = 1'b0;
        repeat (20) @(negedge tick_clk);
        chk(stage == 5'b00010, "R7 pin ignored in power-up timer", int'(stage), 2);
        while (stage == 5'b00010) @(negedge tick_clk);
        chk(stage == 5'b00100, "R7 timer ran on under pin", int'(stage), 4);
        repeat (60) @(negedge tick_clk);
        chk(stage == 5'b00100, "R7 start-up held while pin low", int'(stage), 4);
        chk(core_rst == 1'b1, "R8 core held while pin low", int'(core_rst), 1);
        ext_rst_n = 1'b1;
        measure();
        chk(dur[2] >= OST_LO, "R7 count starts after pin release", dur[2], OST_LO);
        check_release();

        finish_run();
    end

endmodule